// File: doc/BRIEF.md
# Cascadable presettable binary counter

The block is a synchronous up-counter built from a chain of identical 4-bit slices that share one clock. Each slice wraps modulo 16. It can be preset from a parallel input, and it advances only when two separate enables are both high. The first enable goes to every slice in the chain. The second one ripples from slice to slice through each slice's terminal-count signal, so the whole chain steps as one wide counter on a single rising edge.

An active-low reset clears the state at once, without waiting for a clock edge. An active-low load copies the preset value into the counter on the next rising edge, and load wins over counting. The `divEn` input turns the block into a programmable frequency divider. With `divEn` high, the final terminal count reloads the preset value, and `tcOut` then pulses once every 2^TOTAL_W minus preset cycles.

Top module: `cascade_counter`

## Requirements
- R1: While `rstN` is low, `count` is 0 and `tcOut` is 0 at once, whatever the clock or the other inputs do.
- R2: On a rising edge with `loadN` low, `count` takes the value of `preset`, whatever `enPar` and `enTrk` are. Load takes priority over counting.
- R3: On a rising edge with `loadN` high, `enPar` high and `enTrk` high (and no divider reload), `count` increases by one. From all ones it wraps to 0.
- R4: On a rising edge with `loadN` high and `enPar` low, `count` holds its value.
- R5: On a rising edge with `loadN` high and `enTrk` low, `count` holds its value.
- R6: `tcOut` is 1 exactly when every bit of `count` is 1 and `enTrk` is 1. It follows `enTrk` combinationally, and `loadN` has no effect on it.
- R7: Slice k (bits 4k+3..4k) increments only on an edge where every lower slice holds 1111. For example, 0x0F counts to 0x10.
- R8: With `divEn` high and `loadN` high, an edge where `tcOut` is 1 loads `preset`. While enabled, `tcOut` therefore pulses once every 2^TOTAL_W − `preset` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadN | input | 1 | Synchronous parallel load, active low |
| enPar | input | 1 | Count enable shared by all slices |
| enTrk | input | 1 | Count enable into the carry chain |
| divEn | input | 1 | Reload `preset` on the final terminal count |
| preset | input | TOTAL_W | Parallel load value |
| count | output | TOTAL_W | Counter state |
| tcOut | output | 1 | Terminal count of the last slice |

## Verification
The assertions check the following on every cycle:
- reset forcing the state to zero;
- load copying the preset value;
- increment-or-hold, depending on the two enables;
- the gating of the terminal count;
- the divider reload.

The bench's scenarios are needed to show the rest:
- the carry from one slice into the next at 0x0F;
- the wrap from all ones to zero;
- the immediate response of `tcOut` to `enTrk` between edges;
- a reset pulse that lands between clock edges;
- the measured divide period.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
  // Strobes passed from a slice's control logic to its datapath.
  typedef struct packed {
    logic load;
    logic inc;
  } stageStrobe_t;
endpackage

// File: rtl/cnt_stage_ctrl.sv
module cnt_stage_ctrl
  import cascade_counter_pkg::*;
(
  input  logic         loadN,
  input  logic         enPar,
  input  logic         enTrk,
  output stageStrobe_t strobe
);
  always_comb begin
    strobe.load = ~loadN;
    strobe.inc  = loadN & enPar & enTrk;
  end
endmodule

// File: rtl/cnt_stage_dp.sv
module cnt_stage_dp
  import cascade_counter_pkg::*;
#(
  parameter int STAGE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  stageStrobe_t       strobe,
  input  logic [STAGE_W-1:0] preset,
  input  logic               enTrk,
  output logic [STAGE_W-1:0] value,
  output logic               tc
);
  logic [STAGE_W-1:0] valueQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            valueQ <= '0;
    else if (strobe.load) valueQ <= preset;
    else if (strobe.inc)  valueQ <= valueQ + 1'b1;
  end

  assign value = valueQ;
  assign tc    = (&valueQ) & enTrk;
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cascade_counter_pkg::*;
#(
  parameter int STAGE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadN,
  input  logic               enPar,
  input  logic               enTrk,
  input  logic [STAGE_W-1:0] preset,
  output logic [STAGE_W-1:0] value,
  output logic               tc
);
  stageStrobe_t strobe;

  cnt_stage_ctrl u_ctrl (
    .loadN (loadN),
    .enPar (enPar),
    .enTrk (enTrk),
    .strobe(strobe)
  );

  cnt_stage_dp #(.STAGE_W(STAGE_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .preset(preset),
    .enTrk (enTrk),
    .value (value),
    .tc    (tc)
  );
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 2,
  localparam int TOTAL_W = STAGE_W * STAGES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadN,
  input  logic               enPar,
  input  logic               enTrk,
  input  logic               divEn,
  input  logic [TOTAL_W-1:0] preset,
  output logic [TOTAL_W-1:0] count,
  output logic               tcOut
);
  logic [STAGES:0] carry;
  logic            stageLoadN;

  assign carry[0]   = enTrk;
  assign tcOut      = carry[STAGES];
  // Divider reload: the final terminal count acts as a load request.
  assign stageLoadN = loadN & ~(divEn & tcOut);

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    cnt_stage #(.STAGE_W(STAGE_W)) u_stage (
      .clk   (clk),
      .rstN  (rstN),
      .loadN (stageLoadN),
      .enPar (enPar),
      .enTrk (carry[k]),
      .preset(preset[k*STAGE_W +: STAGE_W]),
      .value (count[k*STAGE_W +: STAGE_W]),
      .tc    (carry[k+1])
    );
  end
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int TOTAL_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               loadN,
  input logic               enPar,
  input logic               enTrk,
  input logic               divEn,
  input logic [TOTAL_W-1:0] preset,
  input logic [TOTAL_W-1:0] count,
  input logic               tcOut
);
  logic reload;
  assign reload = divEn & tcOut;

  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |-> (count == '0 && !tcOut));

  a_r2_load_copies: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |=> count == $past(preset));

  a_r3_increments: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !reload && enPar && enTrk) |=> count == TOTAL_W'($past(count) + 1'b1));

  a_r4_hold_par: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !reload && !enPar) |=> $stable(count));

  a_r5_hold_trk: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !reload && !enTrk) |=> $stable(count));

  a_r6_tc_gated: assert property (@(posedge clk) disable iff (!rstN)
    tcOut |-> (enTrk && (&count)));

  a_r8_div_reload: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && divEn && tcOut) |=> count == $past(preset));
endmodule

bind cascade_counter cascade_counter_chk #(.TOTAL_W(TOTAL_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .loadN (loadN),
  .enPar (enPar),
  .enTrk (enTrk),
  .divEn (divEn),
  .preset(preset),
  .count (count),
  .tcOut (tcOut)
);

// File: tb/cascade_counter_bench.sv
module cascade_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadN = 1'b1;
  logic enPar = 1'b0;
  logic enTrk = 1'b0;
  logic divEn = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic tcOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_counter u_cascade_counter (
    .clk(clk), .rstN(rstN), .loadN(loadN), .enPar(enPar), .enTrk(enTrk),
    .divEn(divEn), .preset(preset), .count(count), .tcOut(tcOut)
  );

  // Fields: loadN, enPar, enTrk, preset[8], expected count[8], expected tcOut.
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 8'h0D, 8'h0D, 1'b0}, // R2 load
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h0E, 1'b0}, // R3 count
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h0F, 1'b0}, // R3 count
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0}, // R7 carry into slice 1
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h10, 1'b0}, // R4 hold
    {1'b1, 1'b1, 1'b0, 8'h00, 8'h10, 1'b0}, // R5 hold
    {1'b0, 1'b0, 1'b0, 8'hFE, 8'hFE, 1'b0}, // R2 load with enables low
    {1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1}, // R6 terminal count
    {1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // R3 wrap
    {1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b0}, // R6 gated by enTrk
    {1'b0, 1'b1, 1'b1, 8'h33, 8'h33, 1'b0}, // R2 load over count
    {1'b1, 1'b0, 1'b1, 8'h00, 8'h33, 1'b0}  // R4 hold
  };

  task automatic check(input string req, input logic [W-1:0] actC, input logic [W-1:0] expC,
                       input logic actT, input logic expT);
    total++;
    if (actC !== expC || actT !== expT) begin
      bad++;
      $display("FAIL %s: count=%h tc=%b expected count=%h tc=%b", req, actC, actT, expC, expT);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: state while reset is held from time zero.
    #2;
    check("R1 reset", count, 8'h00, tcOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {loadN, enPar, enTrk} = VEC[i][19:17];
      preset = VEC[i][16:9];
      step();
      check($sformatf("vector %0d", i), count, VEC[i][8:1], tcOut, VEC[i][0]);
    end

    // R6: tcOut follows enTrk between edges, and loadN has no effect on it.
    @(negedge clk);
    loadN = 1'b0; enPar = 1'b0; enTrk = 1'b0; preset = 8'hFF;
    step();
    @(negedge clk);
    loadN = 1'b1;
    enTrk = 1'b1; #1;
    check("R6 tc rises with enTrk", count, 8'hFF, tcOut, 1'b1);
    loadN = 1'b0; #1;
    check("R6 loadN has no effect", count, 8'hFF, tcOut, 1'b1);
    enTrk = 1'b0; #1;
    check("R6 tc falls with enTrk", count, 8'hFF, tcOut, 1'b0);
    loadN = 1'b1;

    // R8: divider with preset FC gives a period of 4 cycles.
    @(negedge clk);
    loadN = 1'b0; preset = 8'hFC; enPar = 1'b1; enTrk = 1'b1;
    step();
    @(negedge clk);
    loadN = 1'b1; divEn = 1'b1;
    begin
      int pulses = 0;
      for (int c = 0; c < 8; c++) begin
        step();
        if (tcOut) pulses++;
      end
      total++;
      if (pulses != 2) begin
        bad++;
        $display("FAIL R8 divider pulses: got=%0d expected=2", pulses);
      end
      // The count started at FC and went through two full periods.
      check("R8 divider phase", count, 8'hFC, tcOut, 1'b0);
    end
    divEn = 1'b0;

    // R1: reset applied between edges takes effect at once.
    @(negedge clk);
    loadN = 1'b0; preset = 8'h5A;
    step();
    loadN = 1'b1;
    #2;
    rstN = 1'b0;
    #1;
    check("R1 mid-cycle reset", count, 8'h00, tcOut, 1'b0);
    @(posedge clk);
    #1;
    check("R1 held through edge", count, 8'h00, tcOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    step();
    check("R3 count after reset", count, 8'h01, tcOut, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule